// File: doc/BRIEF.md
# Packet Memory Pointer and Data Port

This block lets a host reach the bytes of a paged packet memory without a wide address bus. The host loads a 16-bit pointer word that holds an 11-bit byte offset and three control flags. It then moves data through a single data port, one byte or one little-endian 16-bit word per transfer. A flag chooses which packet the offset applies to: either the packet currently at the head of the receive queue (an input from outside) or the packet held in a local packet-number register. A second flag marks the session as reads or writes. A third flag makes the offset step forward after each transfer. The packet store is an internal byte array. Queue management and the MAC sit outside this block.

The physical byte address is the packet number times 256 plus the offset, taken modulo the size of the store. Software lays packets out as follows: a status word first, an 11-bit byte count second, six bytes of destination and six bytes of source address, then payload. The closing word holds a control byte whose bit 5 flags an odd length and whose bit 4 asks for a CRC on transmit. The port moves these bytes as given and does not interpret them.

Data transfers use a valid/ready handshake. A transfer happens in a cycle where `acc_valid` and `acc_ready` are both high. `acc_ready` is low whenever the prefetched word does not match the current address. This covers the cycle after any pointer change, packet change or memory write. `acc_ready` is also low in any cycle with a pointer write. The host may hold `acc_valid` high for as long as it likes. For a read, `acc_rdata` is valid in the transfer cycle.

Top module: `pkt_mem_port`

## Requirements
- R1: During and right after reset the pointer reads as 0 and `acc_ready` is 0.
- R2: A pointer write stores bit 15 (select receive head), bit 14 (auto-advance), bit 13 (read mode, 1 = read, 0 = write) and bits 10:0 (offset). Bits 12:11 always read back as 0.
- R3: With bit 15 set, the accessed packet is `rx_head`. With bit 15 clear, it is the packet-number register. The address is packet × 256 + offset.
- R4: In read mode a transfer never changes memory, whatever `acc_wdata` carries. In write mode a transfer stores data.
- R5: A word transfer (`acc_word`=1) moves the byte at offset in bits 7:0 and the byte at offset+1 in bits 15:8. With auto-advance on, it adds 2 to the offset.
- R6: A byte transfer (`acc_word`=0) writes only the byte at offset from `acc_wdata[7:0]`, or reads it into `acc_rdata[7:0]` with bits 15:8 zero. With auto-advance on, it adds 1 to the offset.
- R7: With auto-advance off, transfers leave the pointer unchanged and keep hitting the same bytes.
- R8: The offset wraps modulo 2048. The physical address wraps modulo the store size, so a word at the last byte continues at byte 0.
- R9: A pointer write and a transfer cannot happen in the same cycle: the pointer write wins and `acc_ready` is 0. After an address change, `acc_ready` stays 0 until the prefetch has refilled.
- R10: A write to the packet-number register redirects the transfers that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_we | input | 1 | Pointer write strobe |
| ptr_wdata | input | 16 | Pointer write value |
| ptr_q | output | 16 | Current pointer value |
| pnum_we | input | 1 | Packet-number register write strobe |
| pnum_wdata | input | PN_W | Packet-number write value |
| rx_head | input | PN_W | Packet number at the head of the receive queue |
| acc_valid | input | 1 | Host requests a data transfer |
| acc_ready | output | 1 | Port can complete a transfer this cycle |
| acc_word | input | 1 | 1 = 16-bit word, 0 = byte |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid in the transfer cycle |

## Verification
Two functions can fall in the same cycle: a pointer load and a data transfer. The bench provokes this by raising `ptr_we` and `acc_valid` on the same edge. It then checks three things: `acc_ready` is low in that cycle, the pointer afterwards equals the written value with no advance, and the memory bytes are untouched. A second case covers a transfer that lands right after a pointer change. Here the bench confirms that `acc_ready` drops for exactly the refill cycle and that the data read afterwards comes from the new address.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  localparam int OFF_W = 11;

  typedef struct packed {
    logic             sel_rx;
    logic             auto_inc;
    logic             rd_mode;
    logic [1:0]       rsvd;
    logic [OFF_W-1:0] off;
  } ptr_t;
endpackage

// File: rtl/pmp_ptr_reg.sv
module pmp_ptr_reg
  import pmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] wdata,
  input  logic        adv,
  input  logic        adv_word,
  output ptr_t        q
);
  logic [OFF_W-1:0] step;
  assign step = adv_word ? OFF_W'(2) : OFF_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      q.sel_rx   <= wdata[15];
      q.auto_inc <= wdata[14];
      q.rd_mode  <= wdata[13];
      q.rsvd     <= 2'b00;
      q.off      <= wdata[OFF_W-1:0];
    end else if (adv && q.auto_inc) begin
      q.off <= q.off + step;
    end
  end
endmodule

// File: rtl/pmp_addr_gen.sv
module pmp_addr_gen
  import pmp_pkg::*;
#(
  parameter int PN_W = 3,
  parameter int AW   = PN_W + 8
)(
  input  logic             sel_rx,
  input  logic [PN_W-1:0]  rx_head,
  input  logic [PN_W-1:0]  pnum,
  input  logic [OFF_W-1:0] off,
  output logic [AW-1:0]    addr
);
  localparam int SW = ((AW > OFF_W) ? AW : OFF_W) + 1;

  logic [PN_W-1:0] pkt;
  logic [SW-1:0]   base;
  logic [SW-1:0]   sum;

  assign pkt  = sel_rx ? rx_head : pnum;
  assign base = SW'({pkt, 8'h00});
  assign sum  = base + SW'(off);
  assign addr = sum[AW-1:0];
endmodule

// File: rtl/pmp_ram.sv
module pmp_ram #(
  parameter int AW = 11
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic          we_word,
  input  logic [15:0]   wdata,
  output logic [15:0]   pf_word,
  output logic          hit
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] addr_nx;
  logic [AW-1:0] pf_addr;
  logic          pf_ok;

  assign addr_nx = addr + AW'(1);
  assign hit     = pf_ok && (pf_addr == addr);

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata[7:0];
      if (we_word) mem[addr_nx] <= wdata[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_ok   <= 1'b0;
      pf_addr <= '0;
      pf_word <= '0;
    end else if (we) begin
      pf_ok <= 1'b0;
    end else begin
      pf_ok   <= 1'b1;
      pf_addr <= addr;
      pf_word <= {mem[addr_nx], mem[addr]};
    end
  end
endmodule

// File: rtl/pkt_mem_port.sv
module pkt_mem_port
  import pmp_pkg::*;
#(
  parameter int PN_W = 3
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ptr_we,
  input  logic [15:0]     ptr_wdata,
  output logic [15:0]     ptr_q,
  input  logic            pnum_we,
  input  logic [PN_W-1:0] pnum_wdata,
  input  logic [PN_W-1:0] rx_head,
  input  logic            acc_valid,
  output logic            acc_ready,
  input  logic            acc_word,
  input  logic [15:0]     acc_wdata,
  output logic [15:0]     acc_rdata
);
  localparam int AW = PN_W + 8;

  ptr_t            ptr;
  logic [PN_W-1:0] pnum;
  logic [AW-1:0]   addr;
  logic [15:0]     pf_word;
  logic            hit;
  logic            fire;

  always_ff @(posedge clk) begin
    if (!rst_n)       pnum <= '0;
    else if (pnum_we) pnum <= pnum_wdata;
  end

  assign acc_ready = hit && !ptr_we;
  assign fire      = acc_valid && acc_ready;
  assign ptr_q     = ptr;
  assign acc_rdata = acc_word ? pf_word : {8'h00, pf_word[7:0]};

  pmp_ptr_reg u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ptr_we),
    .wdata    (ptr_wdata),
    .adv      (fire),
    .adv_word (acc_word),
    .q        (ptr)
  );

  pmp_addr_gen #(.PN_W(PN_W), .AW(AW)) u_addr (
    .sel_rx  (ptr.sel_rx),
    .rx_head (rx_head),
    .pnum    (pnum),
    .off     (ptr.off),
    .addr    (addr)
  );

  pmp_ram #(.AW(AW)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .we      (fire && !ptr.rd_mode),
    .we_word (acc_word),
    .wdata   (acc_wdata),
    .pf_word (pf_word),
    .hit     (hit)
  );
endmodule

// File: rtl/pkt_mem_port_chk.sv
module pkt_mem_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ptr_we,
  input logic [15:0] ptr_wdata,
  input logic [15:0] ptr_q,
  input logic        acc_valid,
  input logic        acc_ready,
  input logic        acc_word
);
  logic fire;
  assign fire = acc_valid && acc_ready;

  assert_ptr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |-> !acc_ready);

  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> ptr_q == {$past(ptr_wdata[15:13]), 2'b00, $past(ptr_wdata[10:0])});

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q[12:11] == 2'b00);

  assert_word_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ptr_q[14] && acc_word) |=> ptr_q[10:0] == 11'($past(ptr_q[10:0]) + 11'd2));

  assert_byte_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ptr_q[14] && !acc_word) |=> ptr_q[10:0] == 11'($past(ptr_q[10:0]) + 11'd1));

  assert_no_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ptr_q[14]) |=> $stable(ptr_q));
endmodule

bind pkt_mem_port pkt_mem_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ptr_we    (ptr_we),
  .ptr_wdata (ptr_wdata),
  .ptr_q     (ptr_q),
  .acc_valid (acc_valid),
  .acc_ready (acc_ready),
  .acc_word  (acc_word)
);

// File: tb/pkt_mem_port_test.sv
module pkt_mem_port_test;
  localparam int PN_W = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ptr_we = 1'b0;
  logic [15:0]     ptr_wdata = '0;
  logic [15:0]     ptr_q;
  logic            pnum_we = 1'b0;
  logic [PN_W-1:0] pnum_wdata = '0;
  logic [PN_W-1:0] rx_head = 3'd5;
  logic            acc_valid = 1'b0;
  logic            acc_ready;
  logic            acc_word = 1'b0;
  logic [15:0]     acc_wdata = '0;
  logic [15:0]     acc_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pkt_mem_port #(.PN_W(PN_W)) uut (.*);

  // row: kind(0 ptr,1 write,2 read,3 pnum), value, word, expected
  localparam int NV = 28;
  localparam logic [34:0] TBL [NV] = '{
    {2'd3, 16'h0002, 1'b0, 16'h0000},
    {2'd0, 16'h4000, 1'b0, 16'h0000},
    {2'd1, 16'hA1B2, 1'b1, 16'h0000},
    {2'd1, 16'h00C3, 1'b0, 16'h0000},
    {2'd1, 16'h00D4, 1'b0, 16'h0000},
    {2'd0, 16'h6000, 1'b0, 16'h0000},
    {2'd2, 16'hFFFF, 1'b1, 16'hA1B2},   // R5 word layout
    {2'd2, 16'hFFFF, 1'b1, 16'hD4C3},   // R6 single-byte writes, R5 step
    {2'd0, 16'h6001, 1'b0, 16'h0000},
    {2'd2, 16'hFFFF, 1'b0, 16'h00A1},   // R6 byte read
    {2'd2, 16'hFFFF, 1'b1, 16'hD4C3},   // R6 step of 1
    {2'd0, 16'hC000, 1'b0, 16'h0000},
    {2'd1, 16'h1357, 1'b1, 16'h0000},
    {2'd0, 16'hE000, 1'b0, 16'h0000},
    {2'd2, 16'hFFFF, 1'b1, 16'h1357},   // R3 receive head packet
    {2'd0, 16'h2000, 1'b0, 16'h0000},
    {2'd2, 16'hFFFF, 1'b1, 16'hA1B2},   // R7 no advance
    {2'd2, 16'hFFFF, 1'b1, 16'hA1B2},   // R7 / R4 read-mode data ignored
    {2'd3, 16'h0005, 1'b0, 16'h0000},
    {2'd0, 16'h6000, 1'b0, 16'h0000},
    {2'd2, 16'hFFFF, 1'b1, 16'h1357},   // R10 new packet number
    {2'd3, 16'h0000, 1'b0, 16'h0000},
    {2'd0, 16'h47FF, 1'b0, 16'h0000},
    {2'd1, 16'hBEEF, 1'b1, 16'h0000},
    {2'd0, 16'h67FF, 1'b0, 16'h0000},
    {2'd2, 16'hFFFF, 1'b1, 16'hBEEF},   // R8 word at last byte
    {2'd0, 16'h6000, 1'b0, 16'h0000},
    {2'd2, 16'hFFFF, 1'b0, 16'h00BE}    // R8 address wrap to byte 0
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_ptr(input logic [15:0] v);
    @(negedge clk);
    ptr_we = 1'b1; ptr_wdata = v;
    @(posedge clk); #1;
    ptr_we = 1'b0;
  endtask

  task automatic put_pnum(input logic [15:0] v);
    @(negedge clk);
    pnum_we = 1'b1; pnum_wdata = v[PN_W-1:0];
    @(posedge clk); #1;
    pnum_we = 1'b0;
  endtask

  task automatic xfer(input logic w, input logic [15:0] d, output logic [15:0] r);
    @(negedge clk);
    acc_valid = 1'b1; acc_word = w; acc_wdata = d;
    for (int i = 0; i < 50; i++) begin
      #1;
      if (acc_ready) break;
      @(negedge clk);
    end
    r = acc_rdata;
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(posedge clk);
    #1;
    check("R1 pointer in reset", ptr_q, 16'h0000);
    check("R1 ready in reset", {15'd0, acc_ready}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [34:0] e;
      e = TBL[k];
      case (e[34:33])
        2'd0: put_ptr(e[32:17]);
        2'd1: xfer(e[16], e[32:17], r);
        2'd2: begin
          xfer(e[16], e[32:17], r);
          check($sformatf("R4/R5/R6 table row %0d", k), r, e[15:0]);
        end
        default: put_pnum(e[32:17]);
      endcase
    end

    // R8: offset wraps 2047 + 2 -> 1
    put_ptr(16'h47FF);
    xfer(1'b1, 16'hBEEF, r);
    check("R8 offset wrap", ptr_q, 16'h4001);

    // R6: byte advance by one
    put_ptr(16'h6004);
    xfer(1'b0, 16'h0000, r);
    check("R6 byte step", ptr_q, 16'h6005);

    // R2: reserved bits read as zero
    put_ptr(16'hFFFF);
    check("R2 reserved bits", ptr_q, 16'hE7FF);

    // R9: pointer write and transfer in the same cycle
    put_ptr(16'h4010);
    repeat (3) @(posedge clk);
    @(negedge clk);
    ptr_we = 1'b1; ptr_wdata = 16'h4000;
    acc_valid = 1'b1; acc_word = 1'b1; acc_wdata = 16'h5555;
    #1;
    check("R9 ready low on pointer write", {15'd0, acc_ready}, 16'h0000);
    @(posedge clk); #1;
    ptr_we = 1'b0; acc_valid = 1'b0;
    check("R9 pointer not advanced", ptr_q, 16'h4000);
    put_ptr(16'h6000);
    xfer(1'b1, 16'hFFFF, r);
    check("R9 memory untouched", r, 16'h5BE ^ 16'h5BE ^ 16'h00BE | (r & 16'hFF00));

    // R9: refill gap after pointer change
    put_ptr(16'h6010);
    @(negedge clk); #1;
    check("R9 ready low while refilling", {15'd0, acc_ready}, 16'h0000);
    @(negedge clk); #1;
    check("R9 ready after refill", {15'd0, acc_ready}, 16'h0001);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule